// File: doc/BRIEF.md
# Three-Channel Center/Edge Motor PWM

This block produces three pairs of motor-drive signals from one shared time base. The time base either counts up and wraps (edge-aligned output) or counts up to the period and back down to zero (center-aligned output). Every channel compares its own active duty value against the time-base position. The result drives a high-side output and a low-side output, which are either complementary or identical.

Period and duty are given in half-ticks. A time-base tick lasts two core clocks: bits [W-1:1] of the position are the tick count and bit 0 is the phase inside the tick. The duty LSB therefore places an edge in the middle of a tick, which doubles the resolution of the tick counter. Each channel has a writable duty buffer and a separate active copy. Only the active copy drives the compare. It is refreshed from the buffer at fixed points of the count, chosen by the mode, so a buffer write never cuts a pulse short. All pins are plain level signals with no handshake. The period and the mode bits are read on every clock.

Top module: `mcpwm3`

## Requirements
- R1: With `mode` = 2'b00 (edge-aligned) and `en` high, the position counts 0, 1, ..., `period` and then wraps to 0, so one period lasts `period`+1 clocks. `cnt_down` stays low.
- R2: With `mode` = 2'b01 (center, single update) or `mode[1]` = 1 (center, double update), the position counts up from 0 to `period`, then down to 1, then reaches 0 again, so one period lasts 2*`period` clocks. `cnt_down` is high from the clock the position reaches `period` until the clock before it reaches 0.
- R3: A channel output is active exactly while position < active duty. In center modes this means it turns active where the falling count passes the duty and inactive where the rising count reaches it. The active time per period is D clocks in edge mode and 2D-1 clocks in center modes (1 <= D < `period`), so each duty step of one is one core clock.
- R4: An active duty of 0 keeps the output inactive for the whole period. An active duty equal to or above `period` keeps it active for the whole period.
- R5: In edge mode the buffer is copied to the active duty on the clock the position wraps from `period` to 0, but not while `upd_dis` is high. In center modes `upd_dis` has no effect.
- R6: In center single-update mode the copy happens only on the clock the position reaches 0.
- R7: In center double-update mode the copy happens both on the clock the position reaches 0 and on the clock it reaches `period`.
- R8: While `en` is low, the position is held at 0 and `cnt_down` is held low. The buffers are copied to the active duties on every clock: always in center modes, and in edge mode only while `upd_dis` is low.
- R9: Channel n drives `pwm_h[n]`/`pwm_l[n]`. With `pair_indep[n]` = 0, `pwm_l[n]` is the inverse of `pwm_h[n]`. With `pair_indep[n]` = 1, `pwm_l[n]` equals `pwm_h[n]`.
- R10: After reset the position is 0, the count direction is up and every active duty is 0. `pwm_h` is therefore all zeros, and a pair in complementary mode shows its low output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Time base runs when high |
| mode | input | 2 | 00 edge, 01 center single update, 1x center double update |
| upd_dis | input | 1 | Blocks edge-mode duty copies |
| period | input | W | Period value in half-ticks |
| duty_buf | input | NCH*W | Duty buffers, channel n at bits [n*W +: W] |
| pair_indep | input | NCH | Per pair: 0 complementary, 1 independent |
| pwm_h | output | NCH | High-side outputs |
| pwm_l | output | NCH | Low-side outputs |
| cnt_down | output | 1 | High while the time base counts down |

## Verification
The hardest behaviour to show from the ports is which point of the count refreshes the active duty. The single-update and double-update modes differ only in the descending half of one period. To expose that difference, the stimulus waits for `cnt_down` to fall, which marks the position just reaching zero. It then writes a new buffer value and counts active clocks separately over the rising half and the falling half. The two modes must give the same rising count and different falling counts. The gating by `upd_dis` is shown in the same way: after a blocked buffer write, the bench disables the time base and checks that the output at position 0 still follows the old duty, then clears `upd_dis` and checks that the output follows the new one.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  localparam logic [1:0] MODE_EDGE   = 2'b00;
  localparam logic [1:0] MODE_CENTER = 2'b01;

  function automatic logic is_edge(input logic [1:0] m);
    return m == MODE_EDGE;
  endfunction

  function automatic logic is_double(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic [W-1:0] period,
  output logic [W-1:0] pos,
  output logic         down,
  output logic         hit_zero,
  output logic         hit_top
);
  import mcpwm_pkg::*;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] pos_nxt;
  logic         down_nxt;

  always_comb begin
    pos_nxt  = pos;
    down_nxt = down;
    hit_zero = 1'b0;
    hit_top  = 1'b0;
    if (!en) begin
      pos_nxt  = '0;
      down_nxt = 1'b0;
    end else if (is_edge(mode)) begin
      down_nxt = 1'b0;
      if (pos >= period) begin
        pos_nxt  = '0;
        hit_zero = 1'b1;
      end else begin
        pos_nxt = pos + ONE;
      end
    end else if (period == '0) begin
      pos_nxt  = '0;
      down_nxt = 1'b0;
      hit_zero = 1'b1;
    end else if (!down) begin
      if (pos >= period - ONE) begin
        pos_nxt  = period;
        down_nxt = 1'b1;
        hit_top  = 1'b1;
      end else begin
        pos_nxt = pos + ONE;
      end
    end else begin
      if (pos <= ONE) begin
        pos_nxt  = '0;
        down_nxt = 1'b0;
        hit_zero = 1'b1;
      end else begin
        pos_nxt = pos - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      down <= 1'b0;
    end else begin
      pos  <= pos_nxt;
      down <= down_nxt;
    end
  end
endmodule

// File: rtl/mcpwm_channel.sv
module mcpwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic         upd_dis,
  input  logic         hit_zero,
  input  logic         hit_top,
  input  logic [W-1:0] duty_in,
  input  logic [W-1:0] pos,
  input  logic [W-1:0] period,
  input  logic         indep,
  output logic         out_h,
  output logic         out_l
);
  import mcpwm_pkg::*;

  logic [W-1:0] duty_act;
  logic         take;
  logic         active;

  always_comb begin
    if (is_edge(mode))
      take = !upd_dis && (!en || hit_zero);
    else
      take = !en || hit_zero || (is_double(mode) && hit_top);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      duty_act <= '0;
    else if (take)
      duty_act <= duty_in;
  end

  assign active = (duty_act != '0) && ((duty_act >= period) || (pos < duty_act));
  assign out_h  = active;
  assign out_l  = indep ? active : !active;
endmodule

// File: rtl/mcpwm3.sv
module mcpwm3 #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             upd_dis,
  input  logic [W-1:0]     period,
  input  logic [NCH*W-1:0] duty_buf,
  input  logic [NCH-1:0]   pair_indep,
  output logic [NCH-1:0]   pwm_h,
  output logic [NCH-1:0]   pwm_l,
  output logic             cnt_down
);
  logic [W-1:0] pos;
  logic         hit_zero;
  logic         hit_top;

  mcpwm_timebase #(.W(W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .mode     (mode),
    .period   (period),
    .pos      (pos),
    .down     (cnt_down),
    .hit_zero (hit_zero),
    .hit_top  (hit_top)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    mcpwm_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .mode     (mode),
      .upd_dis  (upd_dis),
      .hit_zero (hit_zero),
      .hit_top  (hit_top),
      .duty_in  (duty_buf[n*W +: W]),
      .pos      (pos),
      .period   (period),
      .indep    (pair_indep[n]),
      .out_h    (pwm_h[n]),
      .out_l    (pwm_l[n])
    );
  end
endmodule

// File: rtl/mcpwm3_chk.sv
module mcpwm3_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       mode,
  input logic             upd_dis,
  input logic [W-1:0]     period,
  input logic [NCH*W-1:0] duty_buf,
  input logic [NCH-1:0]   pair_indep,
  input logic [NCH-1:0]   pwm_h,
  input logic [NCH-1:0]   pwm_l,
  input logic             cnt_down
);
  assert_edge_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && $past(mode) == 2'b00) |-> !cnt_down);

  assert_down_center_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_down) |-> ($past(mode) != 2'b00));

  assert_idle_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !cnt_down);

  for (genvar n = 0; n < NCH; n++) begin : g_pair
    assert_pair_comp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_indep[n] |-> (pwm_l[n] == !pwm_h[n]));

    assert_pair_indep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pair_indep[n] |-> (pwm_l[n] == pwm_h[n]));

    assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && mode != 2'b00 && duty_buf[n*W +: W] == '0) |=> !pwm_h[n]);

    assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && mode != 2'b00 && period != '0 && duty_buf[n*W +: W] >= period)
      |=> (pwm_h[n] || period != $past(period)));
  end
endmodule

bind mcpwm3 mcpwm3_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .mode       (mode),
  .upd_dis    (upd_dis),
  .period     (period),
  .duty_buf   (duty_buf),
  .pair_indep (pair_indep),
  .pwm_h      (pwm_h),
  .pwm_l      (pwm_l),
  .cnt_down   (cnt_down)
);

// File: tb/mcpwm3_tb.sv
`timescale 1ns/1ps
module mcpwm3_tb;
  localparam int W   = 16;
  localparam int NCH = 3;
  localparam int P   = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en;
  logic [1:0]       mode;
  logic             upd_dis;
  logic [W-1:0]     period;
  logic [NCH*W-1:0] duty_buf;
  logic [NCH-1:0]   pair_indep;
  logic [NCH-1:0]   pwm_h;
  logic [NCH-1:0]   pwm_l;
  logic             cnt_down;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  mcpwm3 #(.W(W), .NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .upd_dis(upd_dis),
    .period(period), .duty_buf(duty_buf), .pair_indep(pair_indep),
    .pwm_h(pwm_h), .pwm_l(pwm_l), .cnt_down(cnt_down)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int w_edge(input int d, input int p);
    if (d == 0) return 0;
    if (d >= p) return p + 1;
    return d;
  endfunction

  function automatic int w_ctr(input int d, input int p);
    if (d == 0) return 0;
    if (d >= p) return 2 * p;
    return 2 * d - 1;
  endfunction

  task automatic set_duty(input int d0, input int d1, input int d2);
    duty_buf = {W'(d2), W'(d1), W'(d0)};
  endtask

  // driver side of the scoreboard
  task automatic expect_w(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor side: measure one window, pop one expected width per channel
  task automatic measure(input int len, input int exp_down, input string dtag);
    int cnt [NCH];
    int dn;
    int bad;
    dn = 0;
    bad = 0;
    for (int c = 0; c < NCH; c++) cnt[c] = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (pwm_h[c]) cnt[c]++;
        if (pwm_l[c] !== (pair_indep[c] ? pwm_h[c] : ~pwm_h[c])) bad++;
      end
      if (cnt_down) dn++;
    end
    for (int c = 0; c < NCH; c++) begin
      if (exp_q.size() == 0) begin
        check(1, 0, "scoreboard empty");
      end else begin
        check(cnt[c], exp_q.pop_front(), tag_q.pop_front());
      end
    end
    check(bad, 0, "R9 pair relation");
    check(dn, exp_down, dtag);
  endtask

  task automatic half_test(input logic [1:0] m, input int exp_dn, input string tag);
    int up_c;
    int dn_c;
    en = 1'b0;
    mode = m;
    set_duty(4, 4, 4);
    wait_clk(2);
    en = 1'b1;
    while (cnt_down == 1'b0) @(negedge clk);
    while (cnt_down == 1'b1) @(negedge clk);
    set_duty(16, 16, 16);
    up_c = 0;
    dn_c = 0;
    while (cnt_down == 1'b0) begin
      if (pwm_h[0]) up_c++;
      @(negedge clk);
    end
    while (cnt_down == 1'b1) begin
      if (pwm_h[0]) dn_c++;
      @(negedge clk);
    end
    check(up_c, 4, {tag, " rising half keeps old duty"});
    check(dn_c, exp_dn, {tag, " falling half"});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    mode = 2'b00;
    upd_dis = 1'b0;
    period = W'(P);
    pair_indep = '0;
    set_duty(0, 0, 0);
    wait_clk(3);
    // R10 reset state
    check(int'(pwm_h), 0, "R10 pwm_h after reset");
    check(int'(pwm_l), 7, "R10 pwm_l after reset");
    check(int'(cnt_down), 0, "R10 direction after reset");
    rst_n = 1'b1;
    wait_clk(2);

    // R1 R3 R4 edge mode, odd / even / full
    set_duty(7, 8, P);
    wait_clk(2);
    en = 1'b1;
    wait_clk(5);
    expect_w(w_edge(7, P), "R3 edge odd duty");
    expect_w(w_edge(8, P), "R3 edge even duty");
    expect_w(w_edge(P, P), "R4 edge duty equal period");
    measure(P + 1, 0, "R1 edge never counts down");

    // R5 update at wrap, R4 extremes
    set_duty(0, 1, 25);
    wait_clk(3 * (P + 1));
    expect_w(0, "R4 edge zero duty");
    expect_w(w_edge(1, P), "R5 edge duty one after wrap update");
    expect_w(w_edge(25, P), "R4 edge duty above period");
    measure(P + 1, 0, "R1 edge direction");

    // R5 blocked updates
    upd_dis = 1'b1;
    set_duty(9, 0, 0);
    wait_clk(3 * (P + 1));
    expect_w(0, "R5 blocked ch0");
    expect_w(1, "R5 blocked ch1");
    expect_w(P + 1, "R5 blocked ch2");
    measure(P + 1, 0, "R1 edge direction");

    // R8 edge disabled with upd_dis high: no copy
    en = 1'b0;
    wait_clk(3);
    check(int'(pwm_h), 3'b110, "R8 disabled edge copy blocked by upd_dis");
    check(int'(cnt_down), 0, "R8 disabled direction");
    upd_dis = 1'b0;
    wait_clk(1);
    check(int'(pwm_h), 3'b001, "R8 disabled continuous copy");

    // R2 R3 center, odd / even / full
    mode = 2'b01;
    set_duty(7, 8, P);
    wait_clk(2);
    en = 1'b1;
    wait_clk(5);
    expect_w(w_ctr(7, P), "R3 center odd duty");
    expect_w(w_ctr(8, P), "R3 center even duty");
    expect_w(w_ctr(P, P), "R4 center duty equal period");
    measure(2 * P, P, "R2 center falling count length");

    // R4 center extremes, loaded while disabled (R8)
    en = 1'b0;
    set_duty(0, 1, 30);
    wait_clk(2);
    en = 1'b1;
    wait_clk(5);
    expect_w(0, "R4 center zero duty");
    expect_w(w_ctr(1, P), "R8 center duty one loaded while idle");
    expect_w(w_ctr(30, P), "R4 center duty above period");
    measure(2 * P, P, "R2 center direction");

    // R6 single update, R7 double update, R5 no effect in center
    upd_dis = 1'b1;
    half_test(2'b01, 3, "R6 single update");
    half_test(2'b10, 15, "R7 double update");
    upd_dis = 1'b0;

    // R9 independent pairs
    pair_indep = 3'b101;
    wait_clk(2);
    expect_w(w_ctr(16, P), "R9 independent ch0 width");
    expect_w(w_ctr(16, P), "R9 complementary ch1 width");
    expect_w(w_ctr(16, P), "R9 independent ch2 width");
    measure(2 * P, P, "R2 center direction double mode");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule